// File: doc/BRIEF.md
# Serial-Bus Channel Select Register

This block is a target on a two-wire serial bus (I2C) that holds a channel-enable register for a one-to-four downstream bus switch. It samples the incoming clock and data lines with the system clock, drops short spikes, and finds START, STOP and repeated START conditions. It then answers to a seven-bit address whose low three bits come from strap pins, so eight of these blocks can share one bus.

A host writes one byte to choose which downstream channels are connected. Any subset is allowed: none, one, several or all four. The host can also read the current selection back. The four enable outputs drive external pass gates. A newly written selection takes effect only at the STOP that closes the transfer.

The active-low reset is asynchronous. It returns the serial state machine to idle at any point in a transfer and disconnects every channel. A host can use it to recover when a downstream bus is stuck low.

Top module: `busfan_select`

## Requirements
- R1: When reset is released, `chan_en` is 4'b0000 and `sda_oe` is 0. No channel is connected and the data line is released.
- R2: The block answers only to address {4'b1110, addr_strap[2:0]}, sent MSB first and followed by the R/W bit (1 = read). On a match it pulls SDA low during the ninth clock (ACK). On any other address it never drives SDA until the next START, and the register keeps its value.
- R3: In a written data byte, bit n enables channel n for n = 0..3. Bits 7:4 are ignored. Every pattern from 4'h0 to 4'hF is accepted.
- R4: A written value reaches `chan_en` only in the clock cycles after the following STOP. Until that STOP, the previous selection stays on `chan_en`.
- R5: Every data byte written to a matching address is ACKed. When several bytes arrive before STOP, only the last one is applied.
- R6: A read to a matching address returns {4'b0000, register} MSB first. The value sent is the applied register, not a pending write. If the master ACKs, the same byte is sent again. After the master NACKs, SDA is released.
- R7: Driving `rst_n` low at any time clears `chan_en` to zero and releases SDA without waiting for a clock edge. It also discards a partly received transfer, and the next transaction works normally.
- R8: A pulse on SCL or SDA lasting fewer than FILT_CYCLES system clocks is ignored. The default is 8 cycles, which is 64 ns at 125 MHz and covers spikes of 50 ns or less.
- R9: A repeated START (START with no STOP before it) begins a new address phase. A pending write survives it and is applied at the later STOP.
- R10: `sda_oe` changes only while the filtered SCL is low. A START and a STOP release SDA on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset; clears the selection and aborts any transfer |
| addr_strap | input | 3 | Low three bits of the target address |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, pull the data line low (open-drain drive) |
| chan_en | output | 4 | Enable for each downstream channel; bit n connects channel n |

## Verification
On every cycle, the assertions check four things. The enable vector never changes except on the cycle after a detected STOP. The data drive never toggles while the filtered clock is high. START and STOP always leave SDA released. The selection is empty when reset ends. The bench scenarios cover what only complete transfers can show: address matching against the straps, the ACK bits, the masking of the upper data bits, last-byte-wins, read-back through a repeated START, spike rejection in the middle of a byte, and recovery from a reset pulled in the middle of a transfer.

// File: rtl/busfan_pkg.sv
// Package: shared types for the channel select target.
// Assumes: one byte per bus transfer unit; bit counter counts 0..8.
package busfan_pkg;

    localparam int BYTE_W = 8;
    localparam int BCNT_W = 4;

    typedef enum logic [2:0] {
        TS_IDLE,      // bus free or not yet addressed
        TS_ADDR,      // shifting in address + R/W
        TS_ADDR_ACK,  // driving ACK for the address
        TS_WDATA,     // shifting in a write byte
        TS_WACK,      // driving ACK for a write byte
        TS_RDATA,     // shifting out the register byte
        TS_RACK,      // sampling the master's ACK/NACK
        TS_SKIP       // not addressed / done, wait for START or STOP
    } tgt_state_t;

endpackage

// File: rtl/busfan_glitch_filter.sv
// Module: busfan_glitch_filter
// Synchronises one bus line into the clk domain. The clean output follows
// the line only after the new level has been held for STABLE_CYCLES
// consecutive samples, so shorter pulses are dropped.
// Assumes: an idle bus line is high; reset value is therefore 1.
module busfan_glitch_filter #(
    parameter int STABLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          clean_q;

    // Two-flop synchroniser followed by a run-length qualifier.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == clean_q) begin
                run_q <= '0;
            end else if (run_q == CW'(STABLE_CYCLES - 1)) begin
                clean_q <= sync_q[1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean_out = clean_q;

endmodule

// File: rtl/busfan_bus_events.sv
// Module: busfan_bus_events
// Turns the filtered clock and data levels into one-cycle event pulses:
// clock rise, clock fall, START and STOP.
// Assumes: inputs are already synchronous and glitch-free.
module busfan_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_p;
    logic sda_p;

    // Hold the previous filtered levels for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Data may only change while the clock is low; a change under a high
    // clock is a bus condition.
    always_comb begin
        scl_rise  = scl_f & ~scl_p;
        scl_fall  = ~scl_f & scl_p;
        start_det = scl_f & scl_p & sda_p & ~sda_f;
        stop_det  = scl_f & scl_p & ~sda_p & sda_f;
    end

endmodule

// File: rtl/busfan_target_fsm.sv
// Module: busfan_target_fsm
// Byte-level target protocol: address match, ACK generation, write capture
// into a pending register, commit on STOP, and read-back of the applied
// register.
// Assumes: event pulses from busfan_bus_events; NCH < 8.
module busfan_target_fsm
    import busfan_pkg::*;
#(
    parameter int         NCH     = 4,
    parameter logic [3:0] ADDR_HI = 4'b1110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     addr_strap,
    input  logic           sda_f,
    input  logic           scl_rise,
    input  logic           scl_fall,
    input  logic           start_det,
    input  logic           stop_det,
    output logic           sda_oe,
    output logic [NCH-1:0] chan_en
);

    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

    tgt_state_t        state_q;
    logic [BCNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              is_read_q;
    logic              mst_ack_q;
    logic              oe_q;
    logic [NCH-1:0]    pend_q;
    logic              pend_vld_q;
    logic [NCH-1:0]    chan_q;
    logic [6:0]        my_addr;
    logic [BYTE_W-1:0] rd_byte;

    // Full target address and the byte returned on reads.
    assign my_addr = {ADDR_HI, addr_strap};
    assign rd_byte = {{(BYTE_W - NCH){1'b0}}, chan_q};

    // Protocol sequencer; bus conditions take priority over clock edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TS_IDLE;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            is_read_q  <= 1'b0;
            mst_ack_q  <= 1'b0;
            oe_q       <= 1'b0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            chan_q     <= '0;
        end else if (stop_det) begin
            state_q    <= TS_IDLE;
            oe_q       <= 1'b0;
            bit_cnt_q  <= '0;
            pend_vld_q <= 1'b0;
            if (pend_vld_q) begin
                chan_q <= pend_q;
            end
        end else if (start_det) begin
            state_q   <= TS_ADDR;
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
        end else begin
            case (state_q)
                TS_ADDR: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
                        if (shreg_q[BYTE_W-1:1] == my_addr) begin
                            oe_q      <= 1'b1;
                            is_read_q <= shreg_q[0];
                            state_q   <= TS_ADDR_ACK;
                        end else begin
                            state_q <= TS_SKIP;
                        end
                    end
                end
                TS_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (is_read_q) begin
                            shreg_q <= rd_byte;
                            oe_q    <= ~rd_byte[BYTE_W-1];
                            state_q <= TS_RDATA;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= TS_WDATA;
                        end
                    end
                end
                TS_WDATA: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
                        pend_q     <= shreg_q[NCH-1:0];
                        pend_vld_q <= 1'b1;
                        oe_q       <= 1'b1;
                        state_q    <= TS_WACK;
                    end
                end
                TS_WACK: begin
                    if (scl_fall) begin
                        oe_q      <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= TS_WDATA;
                    end
                end
                TS_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt_q == LAST_BIT) begin
                            oe_q    <= 1'b0;
                            state_q <= TS_RACK;
                        end else begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            oe_q    <= ~shreg_q[BYTE_W-2];
                        end
                    end
                end
                TS_RACK: begin
                    if (scl_rise) begin
                        mst_ack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mst_ack_q) begin
                            bit_cnt_q <= '0;
                            shreg_q   <= rd_byte;
                            oe_q      <= ~rd_byte[BYTE_W-1];
                            state_q   <= TS_RDATA;
                        end else begin
                            state_q <= TS_SKIP;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_oe  = oe_q;
    assign chan_en = chan_q;

endmodule

// File: rtl/busfan_select.sv
// Module: busfan_select (top)
// Serial-bus target holding a channel-enable register for a 1-to-NCH bus
// switch. Filters both bus lines, detects bus conditions and runs the
// byte protocol. SDA is driven open-drain through sda_oe.
// Assumes: SCL low and high phases each last well over FILT_CYCLES + 4
// system clocks.
module busfan_select #(
    parameter int         NCH         = 4,
    parameter int         FILT_CYCLES = 8,
    parameter logic [3:0] ADDR_HI     = 4'b1110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     addr_strap,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           sda_oe,
    output logic [NCH-1:0] chan_en
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic              scl_clean;
    logic              sda_clean;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;

    assign raw_lines = {sda_in, scl_in};

    // One spike filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        busfan_glitch_filter #(
            .STABLE_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_lines[g]),
            .clean_out(clean_lines[g])
        );
    end

    assign scl_clean = clean_lines[0];
    assign sda_clean = clean_lines[1];

    busfan_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_clean),
        .sda_f    (sda_clean),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    busfan_target_fsm #(
        .NCH    (NCH),
        .ADDR_HI(ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_strap(addr_strap),
        .sda_f     (sda_clean),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );

endmodule

// File: rtl/busfan_select_chk.sv
// Module: busfan_select_chk
// Cycle-level properties of busfan_select, attached by bind.
// Assumes: observes the filtered clock and event pulses inside the top.
module busfan_select_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_f,
    input logic           start_det,
    input logic           stop_det,
    input logic           sda_oe,
    input logic [NCH-1:0] chan_en
);

    // Selection only moves on the cycle after a STOP.
    assert_commit_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> $past(stop_det));

    // Data drive never toggles under a high clock.
    assert_oe_under_low_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // A START always leaves SDA released.
    assert_start_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // A STOP always leaves SDA released.
    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // Leaving reset: nothing connected, nothing driven.
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_en == '0 && !sda_oe));

endmodule

bind busfan_select busfan_select_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_clean),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en)
);

// File: tb/tb_busfan_select.sv
// Bench for busfan_select: vector table of single-byte writes, then
// directed tests for spikes, reset abort, multi-byte, repeated START, reads.
module tb_busfan_select;

    localparam int HALF  = 40;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int NV = 8;
    // {addr7, data8, expect_ack, expected chan after STOP}
    localparam logic [19:0] VEC [NV] = '{
        {7'h75, 8'h05, 1'b1, 4'h5},
        {7'h75, 8'hA0, 1'b1, 4'h0},
        {7'h75, 8'hFF, 1'b1, 4'hF},
        {7'h74, 8'h03, 1'b0, 4'hF},
        {7'h35, 8'h00, 1'b0, 4'hF},
        {7'h75, 8'h00, 1'b1, 4'h0},
        {7'h75, 8'h39, 1'b1, 4'h9},
        {7'h75, 8'h0A, 1'b1, 4'hA}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_gl = 1'b0;
    logic       sda_gl = 1'b0;
    logic       glitch_en = 1'b0;
    logic       scl_in;
    logic       sda_bus;
    logic       sda_oe;
    logic [3:0] chan_en;
    int         n_checks = 0;
    int         n_errors = 0;
    int         viol = 0;
    logic       oe_prev = 1'b0;
    logic       finished = 1'b0;

    always #4 clk = ~clk;

    assign scl_in  = scl_m | scl_gl;
    assign sda_bus = sda_m & ~sda_oe & ~sda_gl;

    busfan_select dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_strap(STRAP),
        .scl_in    (scl_in),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );

    // R10 monitor: drive must not change while the raw clock is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_in) viol++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b0; wait_cyc(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        if (glitch_en) begin
            wait_cyc(5); scl_gl = 1'b1; wait_cyc(6); scl_gl = 1'b0; wait_cyc(HALF/2 - 11);
        end else begin
            wait_cyc(HALF/2);
        end
        scl_m = 1'b1;
        if (glitch_en) begin
            wait_cyc(10); sda_gl = 1'b1; wait_cyc(6); sda_gl = 1'b0; wait_cyc(HALF - 16);
        end else begin
            wait_cyc(HALF);
        end
        scl_m = 1'b0; wait_cyc(HALF/2);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF/2);
        b = sda_bus;
        wait_cyc(HALF/2);
        scl_m = 1'b0; wait_cyc(HALF/2);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] rd;
        logic [3:0] prev;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        check(chan_en == 4'h0, "R1 chan_en after reset", chan_en, 0);
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

        // Vector table: single-byte writes (R2, R3, R4).
        prev = 4'h0;
        for (int v = 0; v < NV; v++) begin
            bus_start();
            write_byte({VEC[v][19:13], 1'b0}, ack);
            check(ack == VEC[v][4], "R2 address ack", ack, VEC[v][4]);
            write_byte(VEC[v][12:5], ack);
            check(ack == VEC[v][4], "R5 data ack", ack, VEC[v][4]);
            check(chan_en == prev, "R4 held before STOP", chan_en, prev);
            bus_stop();
            check(chan_en == VEC[v][3:0], "R3 chan_en after STOP", chan_en, VEC[v][3:0]);
            prev = VEC[v][3:0];
        end

        // R8: spikes on both lines during every bit.
        glitch_en = 1'b1;
        bus_start();
        write_byte(8'hEA, ack);
        check(ack, "R8 address ack with spikes", ack, 1);
        write_byte(8'h0C, ack);
        check(ack, "R8 data ack with spikes", ack, 1);
        glitch_en = 1'b0;
        bus_stop();
        check(chan_en == 4'hC, "R8 value with spikes", chan_en, 4'hC);

        // R7: reset in the middle of a write.
        bus_start();
        write_byte(8'hEA, ack);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        rst_n = 1'b0;
        #3;
        check(chan_en == 4'h0, "R7 async clear", chan_en, 0);
        check(sda_oe == 1'b0, "R7 sda released", sda_oe, 0);
        wait_cyc(3);
        scl_m = 1'b1; sda_m = 1'b1;
        wait_cyc(HALF);
        rst_n = 1'b1;
        wait_cyc(HALF);
        bus_start();
        write_byte(8'hEA, ack);
        check(ack, "R7 ack after recovery", ack, 1);
        write_byte(8'h06, ack);
        bus_stop();
        check(chan_en == 4'h6, "R7 write after recovery", chan_en, 4'h6);

        // R5: several bytes, the last one wins.
        bus_start();
        write_byte(8'hEA, ack);
        write_byte(8'h01, ack);
        check(ack, "R5 byte1 ack", ack, 1);
        write_byte(8'h02, ack);
        check(ack, "R5 byte2 ack", ack, 1);
        write_byte(8'h0B, ack);
        check(ack, "R5 byte3 ack", ack, 1);
        bus_stop();
        check(chan_en == 4'hB, "R5 last byte kept", chan_en, 4'hB);

        // R9: write, repeated START, read returns applied value.
        bus_start();
        write_byte(8'hEA, ack);
        write_byte(8'h03, ack);
        bus_start();
        write_byte(8'hEB, ack);
        check(ack, "R9 read address ack after repeated START", ack, 1);
        read_byte(rd, 1'b1);
        check(rd == 8'h0B, "R9 read shows applied value", rd, 8'h0B);
        check(chan_en == 4'hB, "R9 still old before STOP", chan_en, 4'hB);
        bus_stop();
        check(chan_en == 4'h3, "R9 pending applied at STOP", chan_en, 4'h3);

        // R6: read two bytes, ACK then NACK.
        bus_start();
        write_byte(8'hEB, ack);
        check(ack, "R6 read address ack", ack, 1);
        read_byte(rd, 1'b0);
        check(rd == 8'h03, "R6 first read byte", rd, 8'h03);
        read_byte(rd, 1'b1);
        check(rd == 8'h03, "R6 second read byte", rd, 8'h03);
        wait_cyc(HALF/2);
        check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_stop();
        check(chan_en == 4'h3, "R6 read leaves value", chan_en, 4'h3);

        // R2: read to another address is not answered.
        bus_start();
        write_byte(8'hE9, ack);
        check(!ack, "R2 no ack for other address", ack, 0);
        read_byte(rd, 1'b1);
        check(rd == 8'hFF, "R2 no data driven", rd, 8'hFF);
        bus_stop();

        check(viol == 0, "R10 drive changed under high clock", viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule